// File: doc/BRIEF.md
# Multi-threaded burst read buffer

This block stages data returned by memory burst reads between two bus interfaces that run on unrelated clocks. A fill side, clocked by `fclk`, writes returned read data. A drain side, clocked by `dclk`, hands that data to the requester. The storage is split into independent per-transaction slots, so several read transactions can be in flight at once. Each slot is a ring of fixed-size subsections. A subsection that has been fully read is handed back to the fill side at once, so one transaction can move far more data than a slot holds.

A transaction starts with an allocation request on the fill side, which returns the number of a free slot. It ends when the drain side releases that slot. Finishing a subsection raises a one-cycle strobe on the side that finished it, and the controlling logic uses it to start or continue a bus transaction. When a slot has no room left (fill side) or nothing ready (drain side), a disconnect output tells the blocked side to let go of the bus. Only subsection-granular occupancy crosses between the clocks, as Gray-coded counters through synchronizer chains.

Top module: `rdbuf_burst_buf`

## Requirements
- R1: After reset no strobe or error output is high. An `alloc_req` returns `alloc_gnt` one `fclk` cycle later, with `alloc_id` set to the lowest-numbered free slot, and that slot becomes busy.
- R2: An `alloc_req` while all eight slots are busy raises `alloc_retry` for one cycle instead of `alloc_gnt`.
- R3: A slot holds four subsections of 16 beats of 64 bits. `fill_sub_done` pulses for one `fclk` cycle after the write that completes a subsection, which is every 16th accepted write to that slot.
- R4: An accepted read raises `rd_valid` one `dclk` cycle after `rd_en`, with `rd_data` holding the oldest unread beat of that slot. Beats leave in the order they were written.
- R5: A drained subsection is reused by the same transaction. After 64 beats are written and 16 are read, 16 more writes are accepted, and all 80 beats read back in order.
- R6: The drain side reads only from completed subsections; a partly filled subsection is not readable. `drain_sub_done` pulses together with `rd_valid` on every 16th read of a slot.
- R7: `fill_disc` is high when the slot selected by `wr_slot` holds four completed, undrained subsections. `drain_disc` is high when the slot selected by `rd_slot` holds no completed, undrained subsection.
- R8: A write to a full slot or to a slot that is not allocated raises `wr_err` for one cycle. It stores nothing and does not move the slot's pointers.
- R9: A read from a slot with nothing readable raises `rd_err` instead of `rd_valid` and does not move the slot's pointers.
- R10: `rel_req` with `rel_slot` ends the transaction: both pointers of the slot return to zero, the slot reads as empty, and once the release has crossed to `fclk` the slot can be allocated again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fclk | input | 1 | Fill-side clock |
| frst_n | input | 1 | Fill-side asynchronous reset, active low |
| alloc_req | input | 1 | Request a slot for a new read transaction |
| alloc_gnt | output | 1 | Allocation granted (one-cycle pulse) |
| alloc_id | output | 3 | Number of the granted slot |
| alloc_retry | output | 1 | Allocation refused, all slots busy |
| wr_en | input | 1 | Write one beat of returned data |
| wr_slot | input | 3 | Slot targeted by the write, also selects `fill_disc` |
| wr_data | input | 64 | Returned data beat |
| wr_err | output | 1 | Write refused (slot full or not allocated) |
| fill_sub_done | output | 1 | A subsection was completed by the last write |
| fill_disc | output | 1 | Slot selected by `wr_slot` is full |
| dclk | input | 1 | Drain-side clock |
| drst_n | input | 1 | Drain-side asynchronous reset, active low |
| rd_en | input | 1 | Read one beat |
| rd_slot | input | 3 | Slot targeted by the read, also selects `drain_disc` |
| rd_data | output | 64 | Data beat, valid with `rd_valid` |
| rd_valid | output | 1 | Read accepted, `rd_data` valid |
| rd_err | output | 1 | Read refused (nothing readable) |
| drain_sub_done | output | 1 | A subsection was emptied by the last read |
| drain_disc | output | 1 | Slot selected by `rd_slot` has nothing readable |
| rel_req | input | 1 | End the transaction held in `rel_slot` |
| rel_slot | input | 3 | Slot to release |

## Verification
The bench builds the block with its default parameters: eight slots, four subsections of 16 beats, and two-stage synchronizers. With these values the slot ring wraps and becomes full after 64 writes, so the full, empty, recycle and refusal states are all reached in a few hundred operations. Eight allocations are enough to exhaust the slot pool and reach the retry response. A two-flop crossing settles within four cycles of either clock, so after each operation the bench waits that long and then compares every grant, error, strobe, disconnect and data beat with a per-slot counter model.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;

   // binary to Gray, widths up to 8 bits (zero-extend narrower values)
   function automatic logic [7:0] to_gray(input logic [7:0] b);
      return b ^ (b >> 1);
   endfunction

   // Gray to binary, widths up to 8 bits
   function automatic logic [7:0] from_gray(input logic [7:0] g);
      logic [7:0] b;
      b[7] = g[7];
      for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

endpackage

// File: rtl/rdbuf_sync.sv
module rdbuf_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rdbuf_fill_ctl.sv
module rdbuf_fill_ctl
   import rdbuf_pkg::*;
#(
   parameter int NSLOT  = 8,
   parameter int NSUB   = 4,
   parameter int BEATS  = 16,
   localparam int SLOT_W = $clog2(NSLOT),
   localparam int SUB_W  = $clog2(NSUB),
   localparam int SP_W   = SUB_W + 1,
   localparam int BEAT_W = $clog2(BEATS),
   localparam int ADDR_W = SLOT_W + SUB_W + BEAT_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  alloc_req,
   output logic                  alloc_gnt,
   output logic [SLOT_W-1:0]     alloc_id,
   output logic                  alloc_retry,
   input  logic                  wr_en,
   input  logic [SLOT_W-1:0]     wr_slot,
   output logic                  wr_err,
   output logic                  sub_done,
   output logic                  disc,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [NSLOT*SP_W-1:0] fsub_gray,
   input  logic [NSLOT*SP_W-1:0] dsub_gray_s,
   input  logic [NSLOT-1:0]      rel_tog_s,
   output logic [NSLOT-1:0]      ack_tog
);
   logic [NSLOT-1:0]  busy, full, rel_seen, rel_evt;
   logic [SP_W-1:0]   fsub   [NSLOT];
   logic [SP_W-1:0]   dsub_b [NSLOT];
   logic [BEAT_W-1:0] fbeat  [NSLOT];
   logic              pick_ok, accept;
   logic [SLOT_W-1:0] pick;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign dsub_b[s] = SP_W'(from_gray(8'(dsub_gray_s[s*SP_W +: SP_W])));
      assign full[s]   = SP_W'(fsub[s] - dsub_b[s]) >= SP_W'(NSUB);
   end

   assign rel_evt  = rel_tog_s ^ rel_seen;
   assign accept   = wr_en && busy[wr_slot] && !full[wr_slot];
   assign mem_we   = accept;
   assign mem_addr = {wr_slot, fsub[wr_slot][SUB_W-1:0], fbeat[wr_slot]};
   assign disc     = full[wr_slot];

   // lowest-numbered free slot
   always_comb begin
      pick_ok = 1'b0;
      pick    = '0;
      for (int s = NSLOT - 1; s >= 0; s--)
         if (!busy[s]) begin
            pick_ok = 1'b1;
            pick    = SLOT_W'(s);
         end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= '0;
         rel_seen    <= '0;
         ack_tog     <= '0;
         fsub_gray   <= '0;
         alloc_gnt   <= 1'b0;
         alloc_id    <= '0;
         alloc_retry <= 1'b0;
         wr_err      <= 1'b0;
         sub_done    <= 1'b0;
         for (int s = 0; s < NSLOT; s++) begin
            fsub[s]  <= '0;
            fbeat[s] <= '0;
         end
      end else begin
         alloc_gnt   <= 1'b0;
         alloc_retry <= 1'b0;
         wr_err      <= 1'b0;
         sub_done    <= 1'b0;
         rel_seen    <= rel_tog_s;
         for (int s = 0; s < NSLOT; s++)
            if (rel_evt[s]) begin
               busy[s]                   <= 1'b0;
               fsub[s]                   <= '0;
               fbeat[s]                  <= '0;
               fsub_gray[s*SP_W +: SP_W] <= '0;
               ack_tog[s]                <= ~ack_tog[s];
            end
         if (alloc_req) begin
            if (pick_ok) begin
               busy[pick] <= 1'b1;
               alloc_gnt  <= 1'b1;
               alloc_id   <= pick;
            end else begin
               alloc_retry <= 1'b1;
            end
         end
         if (wr_en) begin
            if (accept) begin
               fbeat[wr_slot] <= fbeat[wr_slot] + 1'b1;
               if (fbeat[wr_slot] == BEAT_W'(BEATS - 1)) begin
                  fsub[wr_slot] <= fsub[wr_slot] + 1'b1;
                  fsub_gray[wr_slot*SP_W +: SP_W] <=
                     SP_W'(to_gray(8'(fsub[wr_slot] + 1'b1)));
                  sub_done <= 1'b1;
               end
            end else begin
               wr_err <= 1'b1;
            end
         end
      end
   end

   // R1
   gnt_slot_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |-> busy[alloc_id]);

   // R3
   fill_done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sub_done |-> !wr_err);

   // R8
   refused_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err && $past(rel_evt == '0) |-> $stable(fsub_gray));

endmodule

// File: rtl/rdbuf_drain_ctl.sv
module rdbuf_drain_ctl
   import rdbuf_pkg::*;
#(
   parameter int NSLOT  = 8,
   parameter int NSUB   = 4,
   parameter int BEATS  = 16,
   localparam int SLOT_W = $clog2(NSLOT),
   localparam int SUB_W  = $clog2(NSUB),
   localparam int SP_W   = SUB_W + 1,
   localparam int BEAT_W = $clog2(BEATS),
   localparam int ADDR_W = SLOT_W + SUB_W + BEAT_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_en,
   input  logic [SLOT_W-1:0]     rd_slot,
   output logic                  rd_valid,
   output logic                  rd_err,
   output logic                  sub_done,
   output logic                  disc,
   input  logic                  rel_req,
   input  logic [SLOT_W-1:0]     rel_slot,
   output logic                  mem_re,
   output logic [ADDR_W-1:0]     mem_raddr,
   output logic [NSLOT*SP_W-1:0] dsub_gray,
   input  logic [NSLOT*SP_W-1:0] fsub_gray_s,
   output logic [NSLOT-1:0]      rel_tog,
   input  logic [NSLOT-1:0]      ack_tog_s
);
   logic [NSLOT-1:0]  closed, empty, ack_seen, ack_evt;
   logic [SP_W-1:0]   dsub   [NSLOT];
   logic [SP_W-1:0]   fsub_b [NSLOT];
   logic [BEAT_W-1:0] dbeat  [NSLOT];
   logic              accept;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign fsub_b[s] = SP_W'(from_gray(8'(fsub_gray_s[s*SP_W +: SP_W])));
      assign empty[s]  = closed[s] || (fsub_b[s] == dsub[s]);

      // R7
      occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !closed[s] |-> SP_W'(fsub_b[s] - dsub[s]) <= SP_W'(NSUB));
   end

   assign ack_evt   = ack_tog_s ^ ack_seen;
   assign accept    = rd_en && !empty[rd_slot];
   assign mem_re    = accept;
   assign mem_raddr = {rd_slot, dsub[rd_slot][SUB_W-1:0], dbeat[rd_slot]};
   assign disc      = empty[rd_slot];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         closed    <= '0;
         ack_seen  <= '0;
         rel_tog   <= '0;
         dsub_gray <= '0;
         rd_valid  <= 1'b0;
         rd_err    <= 1'b0;
         sub_done  <= 1'b0;
         for (int s = 0; s < NSLOT; s++) begin
            dsub[s]  <= '0;
            dbeat[s] <= '0;
         end
      end else begin
         rd_valid <= 1'b0;
         rd_err   <= 1'b0;
         sub_done <= 1'b0;
         ack_seen <= ack_tog_s;
         for (int s = 0; s < NSLOT; s++)
            if (ack_evt[s]) closed[s] <= 1'b0;
         if (rd_en) begin
            if (accept) begin
               rd_valid       <= 1'b1;
               dbeat[rd_slot] <= dbeat[rd_slot] + 1'b1;
               if (dbeat[rd_slot] == BEAT_W'(BEATS - 1)) begin
                  dsub[rd_slot] <= dsub[rd_slot] + 1'b1;
                  dsub_gray[rd_slot*SP_W +: SP_W] <=
                     SP_W'(to_gray(8'(dsub[rd_slot] + 1'b1)));
                  sub_done <= 1'b1;
               end
            end else begin
               rd_err <= 1'b1;
            end
         end
         if (rel_req) begin
            dsub[rel_slot]                   <= '0;
            dbeat[rel_slot]                  <= '0;
            dsub_gray[rel_slot*SP_W +: SP_W] <= '0;
            closed[rel_slot]                 <= 1'b1;
            rel_tog[rel_slot]                <= ~rel_tog[rel_slot];
         end
      end
   end

   // R9
   valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid, rd_err}));

   // R6
   drain_done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sub_done |-> rd_valid);

endmodule

// File: rtl/rdbuf_burst_buf.sv
module rdbuf_burst_buf #(
   parameter int NSLOT       = 8,
   parameter int NSUB        = 4,
   parameter int BEATS       = 16,
   parameter int DATA_W      = 64,
   parameter int SYNC_STAGES = 2,
   localparam int SLOT_W = $clog2(NSLOT)
) (
   input  logic              fclk,
   input  logic              frst_n,
   input  logic              alloc_req,
   output logic              alloc_gnt,
   output logic [SLOT_W-1:0] alloc_id,
   output logic              alloc_retry,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_err,
   output logic              fill_sub_done,
   output logic              fill_disc,
   input  logic              dclk,
   input  logic              drst_n,
   input  logic              rd_en,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              rd_err,
   output logic              drain_sub_done,
   output logic              drain_disc,
   input  logic              rel_req,
   input  logic [SLOT_W-1:0] rel_slot
);
   localparam int SUB_W  = $clog2(NSUB);
   localparam int SP_W   = SUB_W + 1;
   localparam int BEAT_W = $clog2(BEATS);
   localparam int ADDR_W = SLOT_W + SUB_W + BEAT_W;
   localparam int DEPTH  = NSLOT * NSUB * BEATS;

   if (NSUB < 2 || (NSUB & (NSUB - 1)) != 0) begin : g_bad_nsub
      $error("NSUB must be a power of two, at least 2");
   end
   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("BEATS must be a power of two, at least 2");
   end
   if (NSLOT < 2 || (NSLOT & (NSLOT - 1)) != 0) begin : g_bad_nslot
      $error("NSLOT must be a power of two, at least 2");
   end
   if (SP_W > 8) begin : g_bad_ptr
      $error("subsection pointer wider than the Gray helpers");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NSLOT*SP_W-1:0] fsub_gray, fsub_gray_s, dsub_gray, dsub_gray_s;
   logic [NSLOT-1:0]      rel_tog, rel_tog_s, ack_tog, ack_tog_s;
   logic                  mem_we, mem_re;
   logic [ADDR_W-1:0]     mem_waddr, mem_raddr;
   logic [DATA_W-1:0]     mem [DEPTH];

   rdbuf_fill_ctl #(.NSLOT(NSLOT), .NSUB(NSUB), .BEATS(BEATS)) u_fill (
      .clk(fclk), .rst_n(frst_n),
      .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_id(alloc_id),
      .alloc_retry(alloc_retry),
      .wr_en(wr_en), .wr_slot(wr_slot), .wr_err(wr_err),
      .sub_done(fill_sub_done), .disc(fill_disc),
      .mem_we(mem_we), .mem_addr(mem_waddr),
      .fsub_gray(fsub_gray), .dsub_gray_s(dsub_gray_s),
      .rel_tog_s(rel_tog_s), .ack_tog(ack_tog)
   );

   rdbuf_drain_ctl #(.NSLOT(NSLOT), .NSUB(NSUB), .BEATS(BEATS)) u_drain (
      .clk(dclk), .rst_n(drst_n),
      .rd_en(rd_en), .rd_slot(rd_slot), .rd_valid(rd_valid), .rd_err(rd_err),
      .sub_done(drain_sub_done), .disc(drain_disc),
      .rel_req(rel_req), .rel_slot(rel_slot),
      .mem_re(mem_re), .mem_raddr(mem_raddr),
      .dsub_gray(dsub_gray), .fsub_gray_s(fsub_gray_s),
      .rel_tog(rel_tog), .ack_tog_s(ack_tog_s)
   );

   rdbuf_sync #(.W(NSLOT*SP_W), .STAGES(SYNC_STAGES)) u_sync_f2d (
      .clk(dclk), .rst_n(drst_n), .d(fsub_gray), .q(fsub_gray_s));
   rdbuf_sync #(.W(NSLOT), .STAGES(SYNC_STAGES)) u_sync_ack (
      .clk(dclk), .rst_n(drst_n), .d(ack_tog), .q(ack_tog_s));
   rdbuf_sync #(.W(NSLOT*SP_W), .STAGES(SYNC_STAGES)) u_sync_d2f (
      .clk(fclk), .rst_n(frst_n), .d(dsub_gray), .q(dsub_gray_s));
   rdbuf_sync #(.W(NSLOT), .STAGES(SYNC_STAGES)) u_sync_rel (
      .clk(fclk), .rst_n(frst_n), .d(rel_tog), .q(rel_tog_s));

   always_ff @(posedge fclk)
      if (mem_we) mem[mem_waddr] <= wr_data;

   always_ff @(posedge dclk)
      if (mem_re) rd_data <= mem[mem_raddr];

   // R3
   fill_done_write_chk: assert property (@(posedge fclk) disable iff (!frst_n)
      fill_sub_done |-> $past(mem_we));

endmodule

// File: tb/rdbuf_burst_buf_bench.sv
module rdbuf_burst_buf_bench;
   logic        fclk = 1'b0, dclk = 1'b0;
   logic        frst_n = 1'b0, drst_n = 1'b0;
   logic        alloc_req = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rel_req = 1'b0;
   logic [2:0]  wr_slot = '0, rd_slot = '0, rel_slot = '0;
   logic [63:0] wr_data = '0;
   logic        alloc_gnt, alloc_retry, wr_err, fill_sub_done, fill_disc;
   logic        rd_valid, rd_err, drain_sub_done, drain_disc;
   logic [2:0]  alloc_id;
   logic [63:0] rd_data;

   int          nchk = 0, nfail = 0;
   bit          mbusy [8];
   int          wc [8];
   int          rc [8];
   logic [63:0] ring [8][64];

   always #2.5 fclk = ~fclk;
   always #3.5 dclk = ~dclk;

   rdbuf_burst_buf u_rdbuf_burst_buf (
      .fclk(fclk), .frst_n(frst_n), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
      .alloc_id(alloc_id), .alloc_retry(alloc_retry), .wr_en(wr_en),
      .wr_slot(wr_slot), .wr_data(wr_data), .wr_err(wr_err),
      .fill_sub_done(fill_sub_done), .fill_disc(fill_disc),
      .dclk(dclk), .drst_n(drst_n), .rd_en(rd_en), .rd_slot(rd_slot),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err),
      .drain_sub_done(drain_sub_done), .drain_disc(drain_disc),
      .rel_req(rel_req), .rel_slot(rel_slot)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit m_full(input int s);
      return (wc[s] / 16 - rc[s] / 16) >= 4;
   endfunction

   function automatic bit m_ready(input int s);
      return (rc[s] / 16) < (wc[s] / 16);
   endfunction

   task automatic settle();
      repeat (4) @(posedge dclk);
      repeat (4) @(posedge fclk);
   endtask

   task automatic do_alloc(input bit exp_gnt, input logic [2:0] exp_id);
      @(posedge fclk); #1 alloc_req = 1'b1;
      @(posedge fclk); #1 alloc_req = 1'b0;
      chk(exp_gnt ? "R1 grant" : "R2 grant", 64'(alloc_gnt), 64'(exp_gnt));
      chk("R2 retry", 64'(alloc_retry), 64'(!exp_gnt));
      if (exp_gnt) begin
         chk("R1 id", 64'(alloc_id), 64'(exp_id));
         mbusy[exp_id] = 1'b1;
      end
   endtask

   task automatic do_write(input int s, input logic [63:0] d);
      bit ok;
      ok = mbusy[s] && !m_full(s);
      @(posedge fclk); #1 wr_en = 1'b1; wr_slot = 3'(s); wr_data = d;
      @(posedge fclk); #1 wr_en = 1'b0;
      chk("R8 wr_err", 64'(wr_err), 64'(!ok));
      if (ok) begin
         ring[s][wc[s] % 64] = d;
         wc[s]++;
      end
      chk("R3 fill_sub_done", 64'(fill_sub_done), 64'(ok && (wc[s] % 16 == 0)));
   endtask

   task automatic do_read(input int s);
      bit ok;
      ok = m_ready(s);
      @(posedge dclk); #1 rd_en = 1'b1; rd_slot = 3'(s);
      @(posedge dclk); #1 rd_en = 1'b0;
      chk("R9 rd_err", 64'(rd_err), 64'(!ok));
      chk("R4 rd_valid", 64'(rd_valid), 64'(ok));
      if (ok) begin
         chk("R4 rd_data", rd_data, ring[s][rc[s] % 64]);
         rc[s]++;
      end
      chk("R6 drain_sub_done", 64'(drain_sub_done), 64'(ok && (rc[s] % 16 == 0)));
   endtask

   task automatic check_disc(input int s);
      wr_slot = 3'(s); rd_slot = 3'(s);
      #1;
      chk("R7 fill_disc", 64'(fill_disc), 64'(m_full(s)));
      chk("R7 drain_disc", 64'(drain_disc), 64'(!m_ready(s)));
   endtask

   task automatic do_release(input int s);
      @(posedge dclk); #1 rel_req = 1'b1; rel_slot = 3'(s);
      @(posedge dclk); #1 rel_req = 1'b0;
      mbusy[s] = 1'b0; wc[s] = 0; rc[s] = 0;
      settle();
      settle();
   endtask

   initial begin : watchdog
      #900us;
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      for (int s = 0; s < 8; s++) begin mbusy[s] = 1'b0; wc[s] = 0; rc[s] = 0; end
      seed = $urandom(32'd7711);
      repeat (3) @(posedge dclk);
      #1 frst_n = 1'b1; drst_n = 1'b1;
      repeat (2) @(posedge fclk);
      #1;
      // R1 reset state
      chk("R1 reset gnt", 64'(alloc_gnt), 64'(0));
      chk("R1 reset retry", 64'(alloc_retry), 64'(0));
      chk("R1 reset wr_err", 64'(wr_err), 64'(0));
      chk("R1 reset rd_valid", 64'(rd_valid), 64'(0));
      chk("R1 reset rd_err", 64'(rd_err), 64'(0));
      chk("R1 reset fill_sub_done", 64'(fill_sub_done), 64'(0));
      chk("R1 reset drain_sub_done", 64'(drain_sub_done), 64'(0));
      check_disc(0);
      // R8: write to an unallocated slot
      do_write(3, 64'hdead_0003);
      // R1 / R2: exhaust the pool
      for (int i = 0; i < 8; i++) do_alloc(1'b1, 3'(i));
      do_alloc(1'b0, 3'd0);
      // R3 / R4 / R6: one subsection in slot 0
      for (int i = 0; i < 16; i++) do_write(0, 64'h0a00_0000 + 64'(i));
      settle();
      check_disc(0);
      for (int i = 0; i < 16; i++) do_read(0);
      check_disc(0);
      do_read(0);                       // R9 empty slot
      // R7 / R8: fill slot 1 completely, one extra write refused
      for (int i = 0; i < 64; i++) do_write(1, {32'h1111_0000, 32'(i)});
      settle();
      check_disc(1);
      do_write(1, 64'hbad0_bad0);
      for (int i = 0; i < 64; i++) do_read(1);
      settle();
      check_disc(1);
      // R5: recycle a drained subsection in slot 2
      for (int i = 0; i < 64; i++) do_write(2, {32'h2222_0000, 32'(i)});
      settle();
      for (int i = 0; i < 16; i++) do_read(2);
      settle();
      check_disc(2);
      for (int i = 64; i < 80; i++) do_write(2, {32'h2222_0000, 32'(i)});
      chk("R5 beats accepted", 64'(wc[2]), 64'(80));
      settle();
      for (int i = 0; i < 64; i++) do_read(2);
      chk("R5 beats drained", 64'(rc[2]), 64'(80));
      // R6: partly filled subsection is not readable
      for (int i = 0; i < 8; i++) do_write(4, 64'h4444_0000 + 64'(i));
      settle();
      check_disc(4);
      do_read(4);
      // R10: release slot 0, then it is the only slot to allocate
      for (int i = 0; i < 16; i++) do_write(0, 64'h0b00_0000 + 64'(i));
      settle();
      do_release(0);
      check_disc(0);
      do_read(0);
      do_alloc(1'b1, 3'd0);
      do_alloc(1'b0, 3'd0);
      // constrained random mix against the model
      for (int n = 0; n < 600; n++) begin
         int s;
         s = int'($urandom % 8);
         if (($urandom % 100) < 55) do_write(s, {$urandom, $urandom});
         else                       do_read(s);
         settle();
         if (n % 50 == 0) check_disc(s);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule